// File: doc/BRIEF.md
# Erase-Count Wear-Leveling Pool Manager

This block keeps one erase counter per block of a small flash array and uses those counters to spread wear evenly. Each time the flash controller erases a block, it reports the block index. The manager then increments that block's counter and marks the block free for new data. After every fixed number of erase reports it recomputes the mean erase count and re-sorts the blocks into a hot pool (above the mean) and a cold pool (at or below the mean).

When the controller asks for a block to write, the manager grants a free block from the cold pool. If no cold block is free, it grants a free hot block instead. If no block is free at all, it answers with a no-free error.

The manager also watches the spread between the most-erased and least-erased block. When that spread grows too large, it raises a swap request that names one hot block and one cold block. The surrounding controller does the data move; this block only names the pair.

Top module: `wlpool_mgr`

## Requirements
- R1: After reset, all counters are zero and every block is free. The hot mask is all zero, the mean is zero, and allocGrant, allocNoFree and swapReq are low.
- R2: An erase report on eraseIdx adds one to that block's counter and sets its freeMask bit at the next clock edge.
- R3: A counter at its maximum value (2^CNT_W-1) stays there on further erases. It never wraps to zero.
- R4: Erase reports are counted. The edge that samples the RECOMP_EVERY-th report arms a recompute. At the edge after that, meanCount becomes the sum of all counters shifted right by log2(NUM_BLOCKS).
- R5: At that same recompute edge, bit i of hotMask becomes 1 when counter i is strictly above the new mean, and 0 otherwise. A counter equal to the mean is cold.
- R6: hotMask and meanCount change only at a recompute edge.
- R7: An allocate request sampled at an edge is answered at that edge with allocGrant and allocIdx. The chosen block is the free cold block with the lowest counter, with ties going to the lowest index. The granted block's freeMask bit clears.
- R8: If no free cold block exists, the grant goes to the free hot block with the lowest counter, with ties going to the lowest index.
- R9: If no block is free, the request is answered with allocNoFree and no grant. No freeMask bit changes for that request.
- R10: Each edge registers swapReq high when the largest counter minus the smallest counter exceeds DELTA. At the same edge it registers swapHot as the lowest index holding the largest count and swapCold as the lowest index holding the smallest count.
- R11: If an erase report and a grant name the same block at the same edge, the block ends up free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eraseValid | input | 1 | An erase was done on eraseIdx this cycle |
| eraseIdx | input | IDX_W | Index of the erased block |
| allocReq | input | 1 | Request one free block |
| allocGrant | output | 1 | Registered: the request was granted |
| allocIdx | output | IDX_W | Registered: index of the granted block |
| allocNoFree | output | 1 | Registered: the request found no free block |
| swapReq | output | 1 | Registered: the erase-count spread exceeds DELTA |
| swapHot | output | IDX_W | Block holding the largest count |
| swapCold | output | IDX_W | Block holding the smallest count |
| hotMask | output | NUM_BLOCKS | Hot pool membership from the last recompute |
| freeMask | output | NUM_BLOCKS | Blocks currently free |
| meanCount | output | CNT_W | Mean from the last recompute |

## Verification
Results come due at different delays:
- Grant, no-free, freeMask and swap outputs are due one edge after the cycle that holds the stimulus.
- meanCount and hotMask are due at the second edge after the erase report that completes a recompute period.

A behavioural model in the bench applies these same delays at every rising edge. The bench compares the model with the design on the following falling edge, so each result is checked in exactly the cycle it should first appear. Directed phases cover the corner cases: draining every free block, the hot fallback, a counter equal to the mean, an erase colliding with a grant, and saturation. A long random phase then mixes all inputs.

// File: rtl/wlpool_pkg.sv
package wlpool_pkg;
  typedef struct packed {
    logic eraseHit;
    logic recompute;
    logic allocFire;
  } wlStrobe_t;
endpackage

// File: rtl/wlpool_ctrl.sv
module wlpool_ctrl
  import wlpool_pkg::*;
#(
  parameter int RECOMP_EVERY = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      eraseValid,
  input  logic      allocReq,
  output wlStrobe_t strobe
);
  localparam int RC_W = (RECOMP_EVERY > 1) ? $clog2(RECOMP_EVERY) : 1;
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(RECOMP_EVERY - 1);

  logic [RC_W-1:0] evCount;
  logic recompPend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evCount    <= '0;
      recompPend <= 1'b0;
    end else begin
      recompPend <= 1'b0;
      if (eraseValid) begin
        if (evCount == RC_LAST) begin
          evCount    <= '0;
          recompPend <= 1'b1;
        end else begin
          evCount <= evCount + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.eraseHit  = eraseValid;
    strobe.allocFire = allocReq;
    strobe.recompute = recompPend;
  end

  // R4: a recompute only follows an erase report
  assert_recompute_after_erase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.recompute |-> $past(eraseValid));
endmodule

// File: rtl/wlpool_dp.sv
module wlpool_dp
  import wlpool_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int CNT_W      = 8,
  parameter int DELTA      = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  wlStrobe_t                     strobe,
  input  logic [$clog2(NUM_BLOCKS)-1:0] eraseIdx,
  output logic                          allocGrant,
  output logic [$clog2(NUM_BLOCKS)-1:0] allocIdx,
  output logic                          allocNoFree,
  output logic                          swapReq,
  output logic [$clog2(NUM_BLOCKS)-1:0] swapHot,
  output logic [$clog2(NUM_BLOCKS)-1:0] swapCold,
  output logic [NUM_BLOCKS-1:0]         hotMask,
  output logic [NUM_BLOCKS-1:0]         freeMask,
  output logic [CNT_W-1:0]              meanCount
);
  localparam int IDX_W = $clog2(NUM_BLOCKS);
  localparam int SUM_W = CNT_W + IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt [NUM_BLOCKS];

  logic [SUM_W-1:0] sumAll;
  logic [CNT_W-1:0] maxVal, minVal, coldVal, hotVal, meanNext;
  logic [IDX_W-1:0] maxIdx, minIdx, coldIdx, hotIdx, selIdx;
  logic coldFound, hotFound, anyFree, gapOver;

  always_comb begin
    sumAll = '0;
    maxVal = cnt[0]; maxIdx = '0;
    minVal = cnt[0]; minIdx = '0;
    coldFound = 1'b0; coldVal = '0; coldIdx = '0;
    hotFound  = 1'b0; hotVal  = '0; hotIdx  = '0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      sumAll = sumAll + SUM_W'(cnt[i]);
      if (cnt[i] > maxVal) begin maxVal = cnt[i]; maxIdx = IDX_W'(i); end
      if (cnt[i] < minVal) begin minVal = cnt[i]; minIdx = IDX_W'(i); end
      if (freeMask[i] && !hotMask[i] && (!coldFound || cnt[i] < coldVal)) begin
        coldFound = 1'b1; coldVal = cnt[i]; coldIdx = IDX_W'(i);
      end
      if (freeMask[i] && hotMask[i] && (!hotFound || cnt[i] < hotVal)) begin
        hotFound = 1'b1; hotVal = cnt[i]; hotIdx = IDX_W'(i);
      end
    end
    meanNext = CNT_W'(sumAll >> IDX_W);
    gapOver  = int'(maxVal - minVal) > DELTA;
    anyFree  = coldFound | hotFound;
    selIdx   = coldFound ? coldIdx : hotIdx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BLOCKS; i++) cnt[i] <= '0;
      freeMask    <= '1;
      hotMask     <= '0;
      meanCount   <= '0;
      allocGrant  <= 1'b0;
      allocNoFree <= 1'b0;
      allocIdx    <= '0;
      swapReq     <= 1'b0;
      swapHot     <= '0;
      swapCold    <= '0;
    end else begin
      allocGrant  <= strobe.allocFire && anyFree;
      allocNoFree <= strobe.allocFire && !anyFree;
      if (strobe.allocFire && anyFree) allocIdx <= selIdx;
      swapReq  <= gapOver;
      swapHot  <= maxIdx;
      swapCold <= minIdx;
      if (strobe.recompute) begin
        meanCount <= meanNext;
        for (int i = 0; i < NUM_BLOCKS; i++) hotMask[i] <= cnt[i] > meanNext;
      end
      for (int i = 0; i < NUM_BLOCKS; i++) begin
        if (strobe.allocFire && anyFree && selIdx == IDX_W'(i)) freeMask[i] <= 1'b0;
        if (strobe.eraseHit && eraseIdx == IDX_W'(i)) begin
          freeMask[i] <= 1'b1;
          if (cnt[i] != CNT_MAX) cnt[i] <= cnt[i] + 1'b1;
        end
      end
    end
  end

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(allocGrant && allocNoFree));
  assert_nofree_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    allocNoFree |-> ($past(freeMask) == '0));
  assert_grant_was_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    allocGrant |-> |($past(freeMask) & (NUM_BLOCKS'(1) << allocIdx)));
  assert_hot_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe.recompute) |-> ($stable(hotMask) && $stable(meanCount)));
  assert_swap_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    swapReq |-> (swapHot != swapCold));

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : gMono
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] >= $past(cnt[g]));
  end
endmodule

// File: rtl/wlpool_mgr.sv
module wlpool_mgr
  import wlpool_pkg::*;
#(
  parameter int NUM_BLOCKS   = 8,
  parameter int CNT_W        = 8,
  parameter int RECOMP_EVERY = 4,
  parameter int DELTA        = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          eraseValid,
  input  logic [$clog2(NUM_BLOCKS)-1:0] eraseIdx,
  input  logic                          allocReq,
  output logic                          allocGrant,
  output logic [$clog2(NUM_BLOCKS)-1:0] allocIdx,
  output logic                          allocNoFree,
  output logic                          swapReq,
  output logic [$clog2(NUM_BLOCKS)-1:0] swapHot,
  output logic [$clog2(NUM_BLOCKS)-1:0] swapCold,
  output logic [NUM_BLOCKS-1:0]         hotMask,
  output logic [NUM_BLOCKS-1:0]         freeMask,
  output logic [CNT_W-1:0]              meanCount
);
  wlStrobe_t strobe;

  wlpool_ctrl #(.RECOMP_EVERY(RECOMP_EVERY)) uCtrl (
    .clk(clk), .rst_n(rst_n), .eraseValid(eraseValid),
    .allocReq(allocReq), .strobe(strobe)
  );

  wlpool_dp #(.NUM_BLOCKS(NUM_BLOCKS), .CNT_W(CNT_W), .DELTA(DELTA)) uDp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .eraseIdx(eraseIdx),
    .allocGrant(allocGrant), .allocIdx(allocIdx), .allocNoFree(allocNoFree),
    .swapReq(swapReq), .swapHot(swapHot), .swapCold(swapCold),
    .hotMask(hotMask), .freeMask(freeMask), .meanCount(meanCount)
  );
endmodule

// File: tb/wlpool_mgr_test.sv
module wlpool_mgr_test;
  localparam int NB = 8, CW = 8, RE = 4, DL = 6, IW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic eraseValid = 1'b0, allocReq = 1'b0;
  logic [IW-1:0] eraseIdx = '0;
  logic allocGrant, allocNoFree, swapReq;
  logic [IW-1:0] allocIdx, swapHot, swapCold;
  logic [NB-1:0] hotMask, freeMask;
  logic [CW-1:0] meanCount;

  wlpool_mgr #(.NUM_BLOCKS(NB), .CNT_W(CW), .RECOMP_EVERY(RE), .DELTA(DL)) uut (
    .clk(clk), .rst_n(rst_n), .eraseValid(eraseValid), .eraseIdx(eraseIdx),
    .allocReq(allocReq), .allocGrant(allocGrant), .allocIdx(allocIdx),
    .allocNoFree(allocNoFree), .swapReq(swapReq), .swapHot(swapHot),
    .swapCold(swapCold), .hotMask(hotMask), .freeMask(freeMask),
    .meanCount(meanCount)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit running = 0;

  // behavioural reference
  int mc [NB];
  bit mfree [NB];
  bit mhot [NB];
  int mmean, evc;
  bit pend;
  bit eGrant, eNoFree, eSwap;
  int eIdx, eHot, eCold;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int maskOf(input bit m[NB]);
    int r = 0;
    for (int i = 0; i < NB; i++) if (m[i]) r |= (1 << i);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin mc[i] = 0; mfree[i] = 1; mhot[i] = 0; end
      mmean = 0; evc = 0; pend = 0;
      eGrant = 0; eNoFree = 0; eSwap = 0; eIdx = 0; eHot = 0; eCold = 0;
    end else begin
      int mx, mn, sel, bestC, bestH, sum;
      bit nHot [NB];
      bit nPend;
      mx = 0; mn = 0;
      for (int i = 1; i < NB; i++) begin
        if (mc[i] > mc[mx]) mx = i;
        if (mc[i] < mc[mn]) mn = i;
      end
      eSwap = (mc[mx] - mc[mn]) > DL; eHot = mx; eCold = mn;
      bestC = -1; bestH = -1;
      for (int i = 0; i < NB; i++) begin
        if (mfree[i] && !mhot[i] && (bestC < 0 || mc[i] < mc[bestC])) bestC = i;
        if (mfree[i] &&  mhot[i] && (bestH < 0 || mc[i] < mc[bestH])) bestH = i;
      end
      sel = (bestC >= 0) ? bestC : bestH;
      nHot = mhot;
      if (pend) begin
        sum = 0;
        for (int i = 0; i < NB; i++) sum += mc[i];
        mmean = sum >> IW;
        for (int i = 0; i < NB; i++) nHot[i] = mc[i] > mmean;
      end
      mhot = nHot;
      eGrant = allocReq && sel >= 0;
      eNoFree = allocReq && sel < 0;
      if (eGrant) begin eIdx = sel; mfree[sel] = 0; end
      nPend = 0;
      if (eraseValid) begin
        mfree[eraseIdx] = 1;
        if (mc[eraseIdx] < CMAX) mc[eraseIdx]++;
        if (evc == RE - 1) begin evc = 0; nPend = 1; end else evc++;
      end
      pend = nPend;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (running) begin
      chk(allocGrant == eGrant && allocNoFree == eNoFree, "R7 R8 R9 grant/nofree",
          {allocGrant, allocNoFree}, {eGrant, eNoFree});
      if (eGrant) chk(allocIdx == IW'(eIdx), "R7 R8 allocIdx", allocIdx, eIdx);
      chk(int'(freeMask) == maskOf(mfree), "R2 R11 freeMask", freeMask, maskOf(mfree));
      chk(int'(hotMask) == maskOf(mhot), "R5 R6 hotMask", hotMask, maskOf(mhot));
      chk(int'(meanCount) == mmean, "R4 meanCount", meanCount, mmean);
      chk(swapReq == eSwap, "R10 swapReq", swapReq, eSwap);
      if (eSwap) chk(swapHot == IW'(eHot) && swapCold == IW'(eCold), "R10 swap pair",
                     {swapHot, swapCold}, {eHot[IW-1:0], eCold[IW-1:0]});
    end
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input bit ev, input int idx, input bit ar);
    @(negedge clk); #1;
    eraseValid = ev; eraseIdx = IW'(idx); allocReq = ar;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    // R1 reset state
    chk(freeMask == '1 && hotMask == '0 && meanCount == 0 && !allocGrant && !allocNoFree && !swapReq,
        "R1 reset", {freeMask, hotMask}, 16'hff00);
    running = 1;
    // R7/R9: drain all blocks in index order, then request on empty pool
    for (int k = 0; k < NB + 1; k++) step(0, 0, 1);
    idle(2);
    // R4/R5: block 3 four times -> mean 0, block 3 hot, others equal mean stay cold
    for (int k = 0; k < RE; k++) step(1, 3, 0);
    idle(3);
    chk(hotMask == 8'b0000_1000, "R5 equal-to-mean cold", hotMask, 8);
    // R8: only free block is hot
    step(0, 0, 1); idle(2);
    // R7: cold blocks free again
    step(1, 0, 0); step(1, 1, 0); step(0, 0, 1); idle(2);
    // R10: spread exceeds DELTA
    for (int k = 0; k < 7; k++) step(1, 5, 0);
    idle(3);
    chk(swapReq && swapHot == 5 && swapCold == 2, "R10 directed", {swapHot, swapCold}, {3'd5, 3'd2});
    // R11: erase and grant hit the same block together
    step(0, 0, 1); step(1, 6, 0); idle(2);
    step(1, 1, 1); idle(2);
    // R3: saturation
    for (int k = 0; k < CMAX + 20; k++) step(1, 6, 0);
    idle(4);
    chk(mc[6] == CMAX && swapHot == 6, "R3 saturation", swapHot, 6);
    // random mix
    for (int k = 0; k < 3000; k++)
      step(($urandom % 3) == 0, $urandom % NB, ($urandom % 4) == 0);
    idle(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule